// File: doc/BRIEF.md
# Trigger-Window Spy Capture Buffer

This block keeps a debug copy of trigger-primitive words taken around each level-1 accept. It watches a stream that carries one primitive word and a valid flag per bunch crossing. When an accept pulse arrives and the block is armed, it writes a fixed window of seven consecutive crossings into an on-chip memory. A pre-trigger delay line lets the window begin a configurable number of crossings before the accept. Each stored entry is tagged with the accept sequence number and with its crossing position inside the window, so a reader can group the words by trigger.

The memory holds a whole number of windows. Once the last window is written, the block freezes and ignores further accepts until software has read the contents through a registered address/data port and pulses the read-done strobe. That strobe rewinds the write pointer and clears the full flag, and capture re-arms one cycle later. An accept that arrives while a window is still being written is not recorded. It is counted in a saturating dropped-trigger counter.

Top module: `spy_capture_buf`

## Requirements
- R1: After synchronous reset, `full` is 0, `armed` is 1 and `drop_cnt` is 0.
- R2: An accepted `l1a` (armed, no window in progress, no `rd_done` in that cycle) writes exactly 7 entries at consecutive addresses, starting at the current write pointer. Entry k (k = 0..6) holds the primitive word presented k - PRE_DLY cycles after the accept cycle, and has `rd_xing` = k.
- R3: Every entry of a window carries the same `rd_seq`: the number of `l1a` pulses seen since reset before the accepting one, counting every pulse whether or not it was recorded.
- R4: An `l1a` that arrives while a window is being written records nothing and adds 1 to `drop_cnt`. The counter stays at its maximum value (all ones) once reached.
- R5: `full` rises in the cycle after the last entry of the last window (address NUM_WIN*7-1) is written, and `armed` is 0 whenever `full` is 1.
- R6: While `full` is 1, `l1a` pulses change neither the memory contents nor `drop_cnt`, and `full` stays 1 until `rd_done`.
- R7: The entry at `rd_addr` appears on `rd_data`, `rd_valid`, `rd_seq` and `rd_xing` one clock after the address is presented. Reads are allowed at any time.
- R8: `rd_done` clears `full` and returns the write pointer to address 0, with `armed` 0 in the following cycle and 1 in the cycle after. An `l1a` in the `rd_done` cycle or while `armed` is 0 is not recorded. The next accepted window is written from address 0.
- R9: Each entry stores the `prim_valid` flag that accompanied its word, returned on `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| prim_data | input | WORD_W | Primitive word for this crossing |
| prim_valid | input | 1 | Primitive word is valid |
| l1a | input | 1 | Level-1 accept pulse |
| rd_addr | input | ADDR_W | Readout address |
| rd_done | input | 1 | Readout finished; rewind and re-arm |
| rd_data | output | WORD_W | Stored primitive word |
| rd_valid | output | 1 | Stored valid flag |
| rd_seq | output | SEQ_W | Accept sequence number of the entry |
| rd_xing | output | 3 | Crossing position 0..6 within the window |
| full | output | 1 | Memory full; capture frozen |
| armed | output | 1 | Capture is armed |
| drop_cnt | output | DROP_W | Saturating count of accepts dropped mid-window |

## Verification
The stream is a running crossing counter, with a valid flag that follows a modulo-3 rule. A misplaced word, a wrong pre-trigger offset or a lost valid bit therefore shows up as a data mismatch at a known address. A table of four windows varies the idle gap before each accept and the position of an extra accept inside the window, at the first, middle and last slot. This separates correct dropping from a restart or an extra write, and confirms that the window grouping follows the sequence tags. Accepts during the frozen state, in the read-done cycle and in the re-arm gap check that those cycles record nothing yet still advance the sequence count. A window full of extra accepts then drives the drop counter into saturation.

// File: rtl/spy_pkg.sv
package spy_pkg;
  // crossings captured per accept
  localparam int WIN_LEN = 7;
  localparam int SLOT_W  = $clog2(WIN_LEN);
endpackage

// File: rtl/spy_delay_line.sv
module spy_delay_line #(
  parameter int W   = 33,
  parameter int DLY = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (DLY == 0) begin : g_pass
      assign dout = din;
    end else begin : g_pipe
      logic [W-1:0] stage [DLY];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DLY; i++) stage[i] <= '0;
        end else begin
          stage[0] <= din;
          for (int i = 1; i < DLY; i++) stage[i] <= stage[i-1];
        end
      end
      assign dout = stage[DLY-1];
    end
  endgenerate
endmodule

// File: rtl/spy_ctrl.sv
module spy_ctrl
  import spy_pkg::*;
#(
  parameter int NUM_WIN = 32,
  parameter int SEQ_W   = 12,
  parameter int DROP_W  = 8,
  localparam int DEPTH  = NUM_WIN * WIN_LEN,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l1a,
  input  logic              rd_done,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [SEQ_W-1:0]  wr_seq,
  output logic              busy,
  output logic              full,
  output logic              armed,
  output logic [DROP_W-1:0] drop_cnt
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(WIN_LEN - 1);

  logic [SLOT_W-1:0] slot_q;
  logic [SEQ_W-1:0]  l1a_cnt, seq_q;
  logic              accept;

  assign accept  = l1a && armed && !busy && !rd_done;
  assign wr_en   = (accept || busy) && !rd_done;
  assign wr_slot = busy ? slot_q : '0;
  assign wr_seq  = accept ? l1a_cnt : seq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr  <= '0;
      slot_q   <= '0;
      busy     <= 1'b0;
      full     <= 1'b0;
      armed    <= 1'b1;
      l1a_cnt  <= '0;
      seq_q    <= '0;
      drop_cnt <= '0;
    end else begin
      if (l1a) l1a_cnt <= l1a_cnt + 1'b1;
      if (l1a && busy && !rd_done && drop_cnt != '1) drop_cnt <= drop_cnt + 1'b1;
      if (rd_done) begin
        wr_addr <= '0;
        slot_q  <= '0;
        busy    <= 1'b0;
        full    <= 1'b0;
        armed   <= 1'b0;
      end else begin
        if (!armed && !full) armed <= 1'b1;
        if (accept) seq_q <= l1a_cnt;
        if (wr_en) begin
          wr_addr <= wr_addr + 1'b1;
          if (wr_addr == LAST_ADDR) begin
            full  <= 1'b1;
            armed <= 1'b0;
            busy  <= 1'b0;
          end else if (wr_slot == LAST_SLOT) begin
            busy <= 1'b0;
          end else begin
            busy   <= 1'b1;
            slot_q <= wr_slot + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spy_mem.sv
module spy_mem #(
  parameter int DEPTH  = 224,
  parameter int DW     = 48,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DW-1:0]     rdata
);
  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/spy_capture_buf.sv
module spy_capture_buf
  import spy_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int NUM_WIN = 32,
  parameter int PRE_DLY = 2,
  parameter int SEQ_W   = 12,
  parameter int DROP_W  = 8,
  localparam int DEPTH  = NUM_WIN * WIN_LEN,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int ENT_W  = SEQ_W + SLOT_W + 1 + WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] prim_data,
  input  logic              prim_valid,
  input  logic              l1a,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_done,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [SEQ_W-1:0]  rd_seq,
  output logic [SLOT_W-1:0] rd_xing,
  output logic              full,
  output logic              armed,
  output logic [DROP_W-1:0] drop_cnt
);
  logic [WORD_W:0]     tap;
  logic                wr_en, busy;
  logic [ADDR_W-1:0]   wr_addr;
  logic [SLOT_W-1:0]   wr_slot;
  logic [SEQ_W-1:0]    wr_seq;
  logic [ENT_W-1:0]    rd_ent;

  spy_delay_line #(.W(WORD_W + 1), .DLY(PRE_DLY)) u_dly (
    .clk(clk), .rst(rst), .din({prim_valid, prim_data}), .dout(tap)
  );

  spy_ctrl #(.NUM_WIN(NUM_WIN), .SEQ_W(SEQ_W), .DROP_W(DROP_W)) u_ctrl (
    .clk(clk), .rst(rst), .l1a(l1a), .rd_done(rd_done),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_slot(wr_slot), .wr_seq(wr_seq),
    .busy(busy), .full(full), .armed(armed), .drop_cnt(drop_cnt)
  );

  spy_mem #(.DEPTH(DEPTH), .DW(ENT_W)) u_mem (
    .clk(clk), .we(wr_en), .waddr(wr_addr),
    .wdata({wr_seq, wr_slot, tap}),
    .raddr(rd_addr), .rdata(rd_ent)
  );

  assign {rd_seq, rd_xing, rd_valid, rd_data} = rd_ent;
endmodule

// File: rtl/spy_capture_chk.sv
module spy_capture_chk #(
  parameter int DROP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              l1a,
  input logic              rd_done,
  input logic              busy,
  input logic              full,
  input logic              armed,
  input logic [DROP_W-1:0] drop_cnt
);
  logic seen;
  always_ff @(posedge clk) seen <= !rst;

  // R5
  full_disarm_chk: assert property (@(posedge clk) disable iff (rst || !seen)
    full |-> !armed);

  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (rst || !seen)
    (full && !rd_done) |=> full);

  // R4
  drop_inc_chk: assert property (@(posedge clk) disable iff (rst || !seen)
    (l1a && busy && !rd_done && drop_cnt != '1) |=> drop_cnt == $past(drop_cnt) + 1'b1);

  // R4
  drop_sat_chk: assert property (@(posedge clk) disable iff (rst || !seen)
    (drop_cnt == '1) |=> drop_cnt == '1);

  // R8
  rewind_chk: assert property (@(posedge clk) disable iff (rst || !seen)
    rd_done |=> (!full && !armed && !busy));

  // R8
  rearm_chk: assert property (@(posedge clk) disable iff (rst || !seen)
    (rd_done ##1 !rd_done) |=> armed);
endmodule

bind spy_capture_buf spy_capture_chk #(.DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst(rst), .l1a(l1a), .rd_done(rd_done), .busy(busy),
  .full(full), .armed(armed), .drop_cnt(drop_cnt)
);

// File: tb/sim_spy_capture_buf.sv
`timescale 1ns/1ps
module sim_spy_capture_buf;
  localparam int WORD_W = 32, NUM_WIN = 4, PRE_DLY = 2, SEQ_W = 12, DROP_W = 3;
  localparam int DEPTH = NUM_WIN * 7;
  localparam int ADDR_W = $clog2(DEPTH);
  // per row: idle gap, slot (1..6) of an extra accept or 0, expected drop count after row
  localparam int ROW_GAP [NUM_WIN] = '{3, 0, 5, 1};
  localparam int ROW_IN  [NUM_WIN] = '{0, 1, 6, 3};
  localparam int ROW_DRP [NUM_WIN] = '{0, 1, 2, 3};

  logic clk = 0, rst = 1;
  logic [WORD_W-1:0] prim_data = '0;
  logic prim_valid = 0, l1a = 0, rd_done = 0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [WORD_W-1:0] rd_data;
  logic rd_valid, full, armed;
  logic [SEQ_W-1:0] rd_seq;
  logic [2:0] rd_xing;
  logic [DROP_W-1:0] drop_cnt;

  int errors = 0, checks = 0, xc = 100, l1a_total = 0;
  int win_v [NUM_WIN];
  int win_s [NUM_WIN];
  bit done = 0;

  always #4 clk = ~clk;

  spy_capture_buf #(.WORD_W(WORD_W), .NUM_WIN(NUM_WIN), .PRE_DLY(PRE_DLY),
                    .SEQ_W(SEQ_W), .DROP_W(DROP_W)) u0 (
    .clk(clk), .rst(rst), .prim_data(prim_data), .prim_valid(prim_valid),
    .l1a(l1a), .rd_addr(rd_addr), .rd_done(rd_done), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_seq(rd_seq), .rd_xing(rd_xing), .full(full),
    .armed(armed), .drop_cnt(drop_cnt)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit a, input bit d);
    @(negedge clk);
    prim_data  = WORD_W'(xc);
    prim_valid = (xc % 3) != 0;
    l1a = a;
    rd_done = d;
    if (a) l1a_total++;
    xc++;
  endtask

  task automatic rd_chk(input int addr, input int v, input int s, input int k, input string req);
    int d;
    longint act, exp;
    @(negedge clk);
    rd_addr = ADDR_W'(addr);
    @(negedge clk);
    d = v + k - PRE_DLY;
    exp = {32'(d), 1'((d % 3) != 0), 12'(s), 3'(k)};
    act = {rd_data, rd_valid, rd_seq, rd_xing};
    chk(act == exp, req, act, exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(full == 0, "R1 full", full, 0);
    chk(armed == 1, "R1 armed", armed, 1);
    chk(drop_cnt == 0, "R1 drop_cnt", drop_cnt, 0);
    repeat (3) step(0, 0);

    for (int r = 0; r < NUM_WIN; r++) begin
      repeat (ROW_GAP[r]) step(0, 0);
      win_v[r] = xc;
      win_s[r] = l1a_total;
      step(1, 0);
      for (int j = 1; j < 7; j++) step(j == ROW_IN[r], 0);
      step(0, 0);
      chk(drop_cnt == ROW_DRP[r], "R4 drop per row", drop_cnt, ROW_DRP[r]);
    end
    chk(full == 1, "R5 full after last window", full, 1);
    chk(armed == 0, "R5 disarmed when full", armed, 0);

    // accepts while frozen
    step(1, 0); step(0, 0); step(1, 0); step(0, 0);
    chk(drop_cnt == 3, "R6 drop unchanged while full", drop_cnt, 3);
    chk(full == 1, "R6 full held", full, 1);

    // R2 R3 R7 R9 R6: every window intact and tagged
    for (int r = 0; r < NUM_WIN; r++)
      for (int k = 0; k < 7; k++)
        rd_chk(r * 7 + k, win_v[r], win_s[r], k, "R2/R3/R7/R9 entry");

    // R8: rewind with accept in the same cycle and in the re-arm gap
    step(1, 1);
    step(1, 0);
    chk(full == 0, "R8 full cleared", full, 0);
    chk(armed == 0, "R8 armed low after rd_done", armed, 0);
    step(0, 0);
    chk(armed == 1, "R8 re-armed", armed, 1);
    win_v[0] = xc;
    win_s[0] = l1a_total;
    step(1, 0);
    for (int j = 1; j < 7; j++) step(1, 0);
    step(0, 0);
    chk(drop_cnt == 7, "R4 drop saturates", drop_cnt, 7);
    chk(full == 0, "R8 one window not full", full, 0);
    for (int k = 0; k < 7; k++)
      rd_chk(k, win_v[0], win_s[0], k, "R8 window from address 0");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule